// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the array controller of a byte-wide flash store. It watches each host write cycle, made of a command address, a full array address and a data byte. It recognises the multi-write unlock sequences that guard every destructive action. When a sequence completes, it raises a single-cycle request to the embedded engine. The request carries the operation's operands: program address and byte, erase sector or page, or boot lockout location and size.

The decoder also keeps track of whether the part is in normal read mode or identification mode. While identification mode is active, it supplies the two signature bytes for read offsets 00h and 01h. A busy input from the embedded operation timer blocks all command decoding while a program or erase is running. Array storage, the program rule that can only clear bits, and the erase timing are all handled outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous reset the decoder is in read mode: `id_mode` is 0, every request output is 0 and `id_data` is 00h.
- R2: Writes of AAh to 5555h, 55h to 2AAAh and A0h to 5555h, followed by a fourth write, raise `prog_req` one cycle after that fourth write. In that cycle `op_addr` and `prog_data` hold the fourth write's address and data; any data byte is accepted there.
- R3: Command steps compare only address bits 14..0. For example, AAh written to 7D555h counts as a write to 5555h.
- R4: The erase set-up is AAh/55h, 80h at 5555h, then AAh/55h again. A sixth write of 10h at 5555h then raises `chip_erase_req`.
- R5: After the erase set-up, a sixth write of 30h at any address raises `sector_erase_req`. `erase_sector` then equals address bits 18..16 of that write.
- R6: After the erase set-up, a sixth write of 50h at any address raises `page_erase_req`. `erase_sector` equals address bits 18..16 and `erase_page` equals bits 15..12 of that write.
- R7: After the erase set-up, 40h (64 KB block) or 70h (16 KB block) at 5555h must be followed by a write to 7FFFFh or 00000h. That write raises `lock_req`, with `lock_top` = 1 for 7FFFFh and `lock_small` = 1 for 70h. Any other address aborts the sequence without a request.
- R8: AAh/55h followed by 90h at 5555h sets `id_mode`. While `id_mode` is set, `id_data` shows DAh for read offset 00h and B6h for offset 01h, using `rd_addr` bits 7..0. Any other offset gives 00h. `id_data` is 00h whenever `id_mode` is clear. It follows `rd_addr` one cycle later.
- R9: Identification mode ends either on AAh/55h/F0h at 5555h or on a single F0h write at any address.
- R10: A write whose address or data does not match the expected step ends the sequence, clears `id_mode` and raises no request. A new sequence must then start from its first unlock write.
- R11: Writes presented while `busy_in` is 1 are ignored: they neither advance nor abort a sequence and raise no request.
- R12: Each request lasts exactly one cycle, and at most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| busy_in | input | 1 | Embedded operation in progress |
| rd_addr | input | 19 | Read address for identification bytes |
| prog_req | output | 1 | Byte program request pulse |
| chip_erase_req | output | 1 | Whole-array erase request pulse |
| sector_erase_req | output | 1 | 64 KB sector erase request pulse |
| page_erase_req | output | 1 | 4 KB page erase request pulse |
| lock_req | output | 1 | Boot lockout request pulse |
| op_addr | output | 19 | Address of the completing write |
| prog_data | output | 8 | Data of the completing write |
| erase_sector | output | 3 | Sector number for erase requests |
| erase_page | output | 4 | Page number for page erase |
| lock_top | output | 1 | Lockout at top (1) or bottom (0) |
| lock_small | output | 1 | Lockout of 16 KB (1) or 64 KB (0) |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification byte for `rd_addr` |

## Verification
Every request and its operand fields come from registers loaded on the clock edge that accepts the final write, so they are due exactly one cycle after that write. `id_mode` changes on the same edge as the write that enters or leaves identification mode. `id_data` is registered from `rd_addr` and `id_mode`, so it settles one edge after either of them changes, which is two edges after an entry write. The bench drives each write for a single rising edge between falling edges and checks on the following falling edge. For identification bytes it first changes `rd_addr` and then waits one more falling edge, so every sample lands in the cycle its result is due.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] CA_MAIN = 15'h5555;
  localparam logic [CMD_AW-1:0] CA_ALT  = 15'h2AAA;

  localparam logic [7:0] D_KEY1   = 8'hAA;
  localparam logic [7:0] D_KEY2   = 8'h55;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_SETUP  = 8'h80;
  localparam logic [7:0] D_IDENT  = 8'h90;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_PAGE   = 8'h50;
  localparam logic [7:0] D_LOCK64 = 8'h40;
  localparam logic [7:0] D_LOCK16 = 8'h70;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PDATA,
    ST_SETUP,
    ST_KEY3,
    ST_KEY4,
    ST_LOCKADR
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PROG,
    OP_CHIP,
    OP_SECT,
    OP_PAGE,
    OP_LOCK
  } op_t;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output op_t               op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              lock_top,
  output logic              lock_small,
  output logic              id_mode
);

  seq_state_t st_q, st_n;
  op_t        op_q, op_n;
  logic       id_q, id_n;
  logic       small_q, small_n;
  logic       top_q, top_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic accept;
  logic at_main, at_alt;
  logic top_adr, bot_adr;

  assign accept  = wr_en && !busy;
  assign at_main = (wr_addr[CMD_AW-1:0] == CA_MAIN);
  assign at_alt  = (wr_addr[CMD_AW-1:0] == CA_ALT);
  assign top_adr = &wr_addr;
  assign bot_adr = (wr_addr == '0);

  always_comb begin
    st_n    = st_q;
    op_n    = OP_NONE;
    id_n    = id_q;
    small_n = small_q;
    top_n   = top_q;
    if (accept) begin
      st_n = ST_IDLE;
      case (st_q)
        ST_IDLE:
          if (at_main && wr_data == D_KEY1) st_n = ST_KEY1;
          else id_n = 1'b0;
        ST_KEY1:
          if (at_alt && wr_data == D_KEY2) st_n = ST_KEY2;
          else id_n = 1'b0;
        ST_KEY2:
          if (at_main && wr_data == D_PROG)       st_n = ST_PDATA;
          else if (at_main && wr_data == D_SETUP) st_n = ST_SETUP;
          else if (at_main && wr_data == D_IDENT) id_n = 1'b1;
          else id_n = 1'b0;
        ST_PDATA:
          op_n = OP_PROG;
        ST_SETUP:
          if (at_main && wr_data == D_KEY1) st_n = ST_KEY3;
          else id_n = 1'b0;
        ST_KEY3:
          if (at_alt && wr_data == D_KEY2) st_n = ST_KEY4;
          else id_n = 1'b0;
        ST_KEY4:
          if (wr_data == D_SECT)                op_n = OP_SECT;
          else if (wr_data == D_PAGE)           op_n = OP_PAGE;
          else if (at_main && wr_data == D_CHIP) op_n = OP_CHIP;
          else if (at_main && (wr_data == D_LOCK64 || wr_data == D_LOCK16)) begin
            st_n    = ST_LOCKADR;
            small_n = (wr_data == D_LOCK16);
          end else id_n = 1'b0;
        ST_LOCKADR:
          if (top_adr || bot_adr) begin
            op_n  = OP_LOCK;
            top_n = top_adr;
          end else id_n = 1'b0;
        default: id_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      id_q    <= 1'b0;
      small_q <= 1'b0;
      top_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_n;
      op_q    <= op_n;
      id_q    <= id_n;
      small_q <= small_n;
      top_q   <= top_n;
      if (accept) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  assign op         = op_q;
  assign op_addr    = addr_q;
  assign op_data    = data_q;
  assign lock_top   = top_q;
  assign lock_small = small_q;
  assign id_mode    = id_q;

endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom #(
  parameter int          OFS_W  = 8,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  ID_MFR = 8'hDA,
  parameter logic [7:0]  ID_DEV = 8'hB6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DATA_W-1:0] data
);

  logic [DATA_W-1:0] byte_n;

  always_comb begin
    byte_n = '0;
    if (en) begin
      if (ofs == OFS_W'(0))      byte_n = DATA_W'(ID_MFR);
      else if (ofs == OFS_W'(1)) byte_n = DATA_W'(ID_DEV);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= byte_n;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3,
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prog_req,
  output logic              chip_erase_req,
  output logic              sector_erase_req,
  output logic              page_erase_req,
  output logic              lock_req,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [SECT_W-1:0] erase_sector,
  output logic [PAGE_W-1:0] erase_page,
  output logic              lock_top,
  output logic              lock_small,
  output logic              id_mode,
  output logic [DATA_W-1:0] id_data
);

  localparam int SECT_LSB = ADDR_W - SECT_W;
  localparam int PAGE_LSB = SECT_LSB - PAGE_W;

  op_t op;

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .busy       (busy_in),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .op         (op),
    .op_addr    (op_addr),
    .op_data    (prog_data),
    .lock_top   (lock_top),
    .lock_small (lock_small),
    .id_mode    (id_mode)
  );

  fcd_id_rom #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_id (
    .clk  (clk),
    .rst  (rst),
    .en   (id_mode),
    .ofs  (rd_addr[OFS_W-1:0]),
    .data (id_data)
  );

  assign prog_req         = (op == OP_PROG);
  assign chip_erase_req   = (op == OP_CHIP);
  assign sector_erase_req = (op == OP_SECT);
  assign page_erase_req   = (op == OP_PAGE);
  assign lock_req         = (op == OP_LOCK);
  assign erase_sector     = op_addr[ADDR_W-1:SECT_LSB];
  assign erase_page       = op_addr[SECT_LSB-1:PAGE_LSB];

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy_in,
  input logic              prog_req,
  input logic              chip_erase_req,
  input logic              sector_erase_req,
  input logic              page_erase_req,
  input logic              lock_req,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic [SECT_W-1:0] erase_sector,
  input logic              lock_top,
  input logic              id_mode,
  input logic [DATA_W-1:0] id_data
);

  logic [4:0] reqs;
  logic       rst_q = 1'b0;
  assign reqs = {prog_req, chip_erase_req, sector_erase_req, page_erase_req, lock_req};

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      assert_reset_state_R1: assert (!id_mode && reqs == 5'd0 && id_data == '0)
        else $error("reset state wrong");
    end
  end

  assert_prog_operands_R2: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> (op_addr == $past(wr_addr) && prog_data == $past(wr_data)));

  assert_sector_field_R5: assert property (@(posedge clk) disable iff (rst)
    sector_erase_req |-> erase_sector == $past(wr_addr[ADDR_W-1:ADDR_W-SECT_W]));

  assert_lock_target_R7: assert property (@(posedge clk) disable iff (rst)
    lock_req |-> (lock_top == (&$past(wr_addr))) && ((&$past(wr_addr)) || $past(wr_addr) == '0));

  assert_id_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> $past(wr_en && !busy_in && wr_data == 8'h90));

  assert_id_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(id_mode) |-> id_data == '0);

  assert_id_exit_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(id_mode) |-> $past(wr_en && !busy_in));

  assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_in) |=> reqs == 5'd0);

  assert_single_req_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqs));

  assert_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    (reqs != 5'd0) |=> reqs == 5'd0);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .wr_en            (wr_en),
  .wr_addr          (wr_addr),
  .wr_data          (wr_data),
  .busy_in          (busy_in),
  .prog_req         (prog_req),
  .chip_erase_req   (chip_erase_req),
  .sector_erase_req (sector_erase_req),
  .page_erase_req   (page_erase_req),
  .lock_req         (lock_req),
  .op_addr          (op_addr),
  .prog_data        (prog_data),
  .erase_sector     (erase_sector),
  .lock_top         (lock_top),
  .id_mode          (id_mode),
  .id_data          (id_data)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 40;

  // {addr[18:0], data[7:0], kind[2:0], aux{top,small}}
  // kind: 0 none, 1 program, 2 chip, 3 sector, 4 page, 5 lockout
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    {19'h05555, 8'hAA, 3'd0, 2'b00}, {19'h02AAA, 8'h55, 3'd0, 2'b00},
    {19'h05555, 8'hA0, 3'd0, 2'b00}, {19'h12345, 8'h3C, 3'd1, 2'b00},
    {19'h05555, 8'hAA, 3'd0, 2'b00}, {19'h02AAA, 8'h55, 3'd0, 2'b00},
    {19'h05555, 8'h80, 3'd0, 2'b00}, {19'h05555, 8'hAA, 3'd0, 2'b00},
    {19'h02AAA, 8'h55, 3'd0, 2'b00}, {19'h05555, 8'h10, 3'd2, 2'b00},
    {19'h05555, 8'hAA, 3'd0, 2'b00}, {19'h02AAA, 8'h55, 3'd0, 2'b00},
    {19'h05555, 8'h80, 3'd0, 2'b00}, {19'h05555, 8'hAA, 3'd0, 2'b00},
    {19'h02AAA, 8'h55, 3'd0, 2'b00}, {19'h3ABCD, 8'h30, 3'd3, 2'b00},
    {19'h05555, 8'hAA, 3'd0, 2'b00}, {19'h02AAA, 8'h55, 3'd0, 2'b00},
    {19'h05555, 8'h80, 3'd0, 2'b00}, {19'h05555, 8'hAA, 3'd0, 2'b00},
    {19'h02AAA, 8'h55, 3'd0, 2'b00}, {19'h5E123, 8'h50, 3'd4, 2'b00},
    {19'h05555, 8'hAA, 3'd0, 2'b00}, {19'h02AAA, 8'h55, 3'd0, 2'b00},
    {19'h05555, 8'h80, 3'd0, 2'b00}, {19'h05555, 8'hAA, 3'd0, 2'b00},
    {19'h02AAA, 8'h55, 3'd0, 2'b00}, {19'h05555, 8'h40, 3'd0, 2'b00},
    {19'h7FFFF, 8'h00, 3'd5, 2'b10},
    {19'h05555, 8'hAA, 3'd0, 2'b00}, {19'h02AAA, 8'h55, 3'd0, 2'b00},
    {19'h05555, 8'h80, 3'd0, 2'b00}, {19'h05555, 8'hAA, 3'd0, 2'b00},
    {19'h02AAA, 8'h55, 3'd0, 2'b00}, {19'h05555, 8'h70, 3'd0, 2'b00},
    {19'h00000, 8'hFF, 3'd5, 2'b01},
    {19'h05555, 8'hAA, 3'd0, 2'b00}, {19'h02AAB, 8'h55, 3'd0, 2'b00},
    {19'h05555, 8'hA0, 3'd0, 2'b00}, {19'h11111, 8'h00, 3'd0, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy_in = 1'b0;
  logic [18:0] rd_addr = '0;
  logic        prog_req, chip_erase_req, sector_erase_req, page_erase_req, lock_req;
  logic [18:0] op_addr;
  logic [7:0]  prog_data;
  logic [2:0]  erase_sector;
  logic [3:0]  erase_page;
  logic        lock_top, lock_small, id_mode;
  logic [7:0]  id_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_in(busy_in), .rd_addr(rd_addr),
    .prog_req(prog_req), .chip_erase_req(chip_erase_req),
    .sector_erase_req(sector_erase_req), .page_erase_req(page_erase_req),
    .lock_req(lock_req), .op_addr(op_addr), .prog_data(prog_data),
    .erase_sector(erase_sector), .erase_page(erase_page),
    .lock_top(lock_top), .lock_small(lock_small),
    .id_mode(id_mode), .id_data(id_data)
  );

  function automatic logic [4:0] reqs();
    return {prog_req, chip_erase_req, sector_erase_req, page_erase_req, lock_req};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    do_write(19'h05555, 8'hAA);
    do_write(19'h02AAA, 8'h55);
  endtask

  task automatic erase_setup();
    unlock();
    do_write(19'h05555, 8'h80);
    unlock();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reqs", 32'(reqs()), 32'd0);
    check("R1 id_mode", 32'(id_mode), 32'd0);
    check("R1 id_data", 32'(id_data), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // vector walk: R2 R4 R5 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] va;
      logic [7:0]  vd;
      logic [2:0]  vk;
      logic [1:0]  vx;
      logic [4:0]  er;
      string       tag;
      {va, vd, vk, vx} = VEC[i];
      do_write(va, vd);
      case (vk)
        3'd1: begin er = 5'b10000; tag = "R2"; end
        3'd2: begin er = 5'b01000; tag = "R4"; end
        3'd3: begin er = 5'b00100; tag = "R5"; end
        3'd4: begin er = 5'b00010; tag = "R6"; end
        3'd5: begin er = 5'b00001; tag = "R7"; end
        default: begin er = 5'b00000; tag = (i >= 36) ? "R10" : "R12"; end
      endcase
      check(tag, 32'(reqs()), 32'(er));
      if (vk == 3'd1) begin
        check("R2 addr", 32'(op_addr), 32'(va));
        check("R2 data", 32'(prog_data), 32'(vd));
      end
      if (vk == 3'd3 || vk == 3'd4) check({tag, " sector"}, 32'(erase_sector), 32'(va[18:16]));
      if (vk == 3'd4) check("R6 page", 32'(erase_page), 32'(va[15:12]));
      if (vk == 3'd5) check("R7 top/small", 32'({lock_top, lock_small}), 32'(vx));
    end

    // R3: upper address bits ignored on command steps
    do_write(19'h7D555, 8'hAA);
    do_write(19'h42AAA, 8'h55);
    do_write(19'h35555, 8'hA0);
    do_write(19'h6789A, 8'h81);
    check("R3 prog_req", 32'(reqs()), 32'b10000);
    check("R3 addr", 32'(op_addr), 32'h6789A);
    // R12: pulse is one cycle
    @(negedge clk);
    check("R12 pulse width", 32'(reqs()), 32'd0);

    // R8: identification entry and bytes
    unlock();
    do_write(19'h05555, 8'h90);
    check("R8 id_mode", 32'(id_mode), 32'd1);
    rd_addr = 19'h00000; @(negedge clk);
    check("R8 byte0", 32'(id_data), 32'hDA);
    rd_addr = 19'h12301; @(negedge clk);
    check("R8 byte1", 32'(id_data), 32'hB6);
    rd_addr = 19'h00005; @(negedge clk);
    check("R8 other", 32'(id_data), 32'h00);

    // R9: three-write exit
    unlock();
    do_write(19'h05555, 8'hF0);
    check("R9 exit3", 32'(id_mode), 32'd0);
    rd_addr = 19'h00000; @(negedge clk);
    check("R8 id_data outside mode", 32'(id_data), 32'h00);
    // R9: single F0 exit
    unlock();
    do_write(19'h05555, 8'h90);
    do_write(19'h31234, 8'hF0);
    check("R9 exit1", 32'(id_mode), 32'd0);

    // R10: broken sequence leaves identification mode
    unlock();
    do_write(19'h05555, 8'h90);
    unlock();
    do_write(19'h05555, 8'h33);
    check("R10 id cleared", 32'(id_mode), 32'd0);
    // R10: unknown final erase code
    erase_setup();
    do_write(19'h05555, 8'h20);
    check("R10 bad code", 32'(reqs()), 32'd0);
    // R7: wrong lockout address aborts
    erase_setup();
    do_write(19'h05555, 8'h40);
    do_write(19'h12345, 8'h00);
    check("R7 bad lock addr", 32'(reqs()), 32'd0);

    // R11: a bad write while busy does not abort
    do_write(19'h05555, 8'hAA);
    busy_in = 1'b1;
    do_write(19'h02AAB, 8'h00);
    busy_in = 1'b0;
    do_write(19'h02AAA, 8'h55);
    do_write(19'h05555, 8'hA0);
    do_write(19'h00042, 8'h7E);
    check("R11 seq survives busy", 32'(reqs()), 32'b10000);
    // R11: completing write while busy raises nothing
    unlock();
    do_write(19'h05555, 8'hA0);
    busy_in = 1'b1;
    do_write(19'h00043, 8'h11);
    check("R11 final ignored", 32'(reqs()), 32'd0);
    busy_in = 1'b0;
    do_write(19'h00044, 8'h22);
    check("R11 still armed", 32'(reqs()), 32'b10000);
    check("R11 addr", 32'(op_addr), 32'h00044);

    // R1: reset mid-sequence
    unlock();
    do_write(19'h05555, 8'h90);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset id_mode", 32'(id_mode), 32'd0);

    finish_sim();
  end

endmodule